// File: doc/BRIEF.md
# Indexed Bank-Switching Memory Mapper

This block sits between an 8-bit CPU bus and a cartridge's program and pattern memories. Software picks a bank register by writing its number into an index window, then loads that register by writing into a data window. The stored bank numbers turn CPU program addresses and video pattern addresses into wide physical addresses, with a chip select for ROM or RAM.

Register 8 controls the 8 KB window at CPU 0x6000. It can map a ROM bank there, map RAM bank 0, or leave the window open so that no memory answers. Register 12 gives a nametable mirroring code, with its two lowest values swapped. Data writes aimed at indices 13 to 15 go out on a side port to a separate interrupt-counter block. Two configuration inputs shrink the program and pattern bank ranges. An outer-bank input fills the program bank bits that the program mask hides.

Top module: `bank_mapper_top`

## Requirements
- R1: A CPU write (cpu_we high at a rising clock edge) with cpu_addr in 0x8000–0x9FFF stores cpu_wdata[3:0] as the current index. Bits [7:4] are ignored.
- R2: A CPU write with cpu_addr in 0xA000–0xBFFF stores cpu_wdata into bank register `index`, for index 0 to 12. The new value shows on the outputs right after that clock edge. Writes with the address in any other window change neither the index nor any register.
- R3: Pattern slot n = ppu_addr[12:10] uses register n, so registers 0 to 7 serve video windows 0x0000 to 0x1C00 in 1 KB steps. chr_addr = {bank, ppu_addr[9:0]}.
- R4: A pattern bank is its register ANDed with 0xFF, or with 0x7F when cfg_small_chr is 1.
- R5: CPU windows 0x8000, 0xA000 and 0xC000 (cpu_addr[15:13] = 4, 5, 6) use registers 9, 10 and 11, with prg_rom_cs = 1. prg_addr = {bank, cpu_addr[12:0]}.
- R6: Window 0xE000 always maps the program bank (0xFF AND mask) OR (outer_bank AND NOT mask), with prg_rom_cs = 1.
- R7: Every program ROM bank is (reg AND mask) OR (outer_bank AND NOT mask). The mask is 0x1F, or 0x0F when cfg_small_prg is 1.
- R8: Register 8 bits [7:6] set the 0x6000–0x7FFF window. Values 00 and 10 map ROM bank R7(reg 8) with prg_rom_cs = 1. Value 01 asserts no chip select. Value 11 maps RAM bank 0 with prg_ram_cs = 1 and prg_addr = {0, cpu_addr[12:0]}.
- R9: Below 0x6000 neither chip select is asserted, and prg_addr = {0, cpu_addr[12:0]}. prg_rom_cs and prg_ram_cs are never both 1.
- R10: mirror_code = reg12[1:0] XOR {0, NOT reg12[1]}. Values 0 and 1 swap, 2 and 3 pass through, and bits [7:2] have no effect.
- R11: In the cycle of a data-window write with the index at 13, 14 or 15, irq_wr is 1, irq_reg_sel shows the index and irq_wr_data shows the byte. Such writes change none of registers 0 to 12. irq_wr is 0 at all other times.
- R12: An active-low rst_n clears the index and all registers, which gives mirror_code = 1 and all banks 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| ppu_addr | input | 13 | Video pattern address |
| cfg_small_prg | input | 1 | Selects the 0x0F program mask |
| cfg_small_chr | input | 1 | Selects the 0x7F pattern mask |
| outer_bank | input | 8 | Fills program bank bits outside the mask |
| prg_addr | output | 21 | Physical program address |
| prg_rom_cs | output | 1 | Program ROM select |
| prg_ram_cs | output | 1 | Work RAM select |
| chr_addr | output | 18 | Physical pattern address |
| mirror_code | output | 2 | Nametable mirroring code |
| irq_wr | output | 1 | Write strobe for the interrupt block |
| irq_reg_sel | output | 4 | Index of that write |
| irq_wr_data | output | 8 | Data of that write |

## Verification
A table of address pairs covers every CPU window and every pattern slot, including the first and last byte of a window. A register used for the wrong slot, or a bit slice taken at the wrong point, therefore gives a visibly wrong physical address. The program bank values are chosen so that 0x27 overflows the mask and 0x1E does not, and an outer bank of 0xA5 is tried with both masks, which separates the mask from the fill term. All four low-window modes and all four mirroring values are applied. Writes to indices 13 to 15 and to unrelated windows are followed by read-backs of the slots they could have corrupted.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
    localparam int DATA_W        = 8;
    localparam int IDX_W         = 4;
    localparam int NUM_BANK_REGS = 13;
    localparam int NUM_CHR_SLOTS = 8;
    localparam int NUM_PRG_SWAP  = 3;
    localparam int REG_LOW_CTRL  = 8;
    localparam int REG_MIRROR    = 12;
    localparam int IRQ_FIRST_IDX = 13;

    localparam logic [2:0] WIN_LOW  = 3'd3;
    localparam logic [2:0] WIN_IDX  = 3'd4;
    localparam logic [2:0] WIN_DATA = 3'd5;
    localparam logic [2:0] WIN_TOP  = 3'd7;

    localparam logic [DATA_W-1:0] PRG_MASK_FULL  = 8'h1F;
    localparam logic [DATA_W-1:0] PRG_MASK_SMALL = 8'h0F;
    localparam logic [DATA_W-1:0] CHR_MASK_FULL  = 8'hFF;
    localparam logic [DATA_W-1:0] CHR_MASK_SMALL = 8'h7F;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        LOW_ROM_A = 2'b00,
        LOW_OPEN  = 2'b01,
        LOW_ROM_B = 2'b10,
        LOW_RAM   = 2'b11
    } low_mode_e;

    typedef struct packed {
        logic [IDX_W-1:0]               idx;
        byte_t [NUM_BANK_REGS-1:0]      bank;
    } regs_t;
endpackage

// File: rtl/mapper_regfile.sv
module mapper_regfile
    import mapper_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cpu_win,
    input  logic               cpu_we,
    input  byte_t              cpu_wdata,
    output regs_t              regs_q,
    output logic               irq_wr,
    output logic [IDX_W-1:0]   irq_reg_sel,
    output byte_t              irq_wr_data
);
    regs_t regs_d;

    always_comb begin
        regs_d      = regs_q;
        irq_wr      = 1'b0;
        irq_reg_sel = regs_q.idx;
        irq_wr_data = cpu_wdata;
        if (cpu_we) begin
            if (cpu_win == WIN_IDX) begin
                regs_d.idx = cpu_wdata[IDX_W-1:0];
            end else if (cpu_win == WIN_DATA) begin
                for (int i = 0; i < NUM_BANK_REGS; i++) begin
                    if (regs_q.idx == IDX_W'(i)) regs_d.bank[i] = cpu_wdata;
                end
                irq_wr = (regs_q.idx >= IDX_W'(IRQ_FIRST_IDX));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end
endmodule

// File: rtl/mapper_prg_map.sv
module mapper_prg_map
    import mapper_pkg::*;
#(
    parameter int CPU_AW = 16,
    localparam int OFS_W = CPU_AW - 3,
    localparam int OUT_W = DATA_W + OFS_W
) (
    input  logic [CPU_AW-1:0]        cpu_addr,
    input  byte_t                    low_reg,
    input  byte_t [NUM_PRG_SWAP-1:0] swap_regs,
    input  logic                     small_prg,
    input  byte_t                    outer_bank,
    output logic [OUT_W-1:0]         prg_addr,
    output logic                     rom_cs,
    output logic                     ram_cs
);
    logic [2:0] win;
    byte_t      mask;
    byte_t      bank;
    byte_t      mixed [NUM_PRG_SWAP+2];
    low_mode_e  mode;

    assign win  = cpu_addr[CPU_AW-1:CPU_AW-3];
    assign mask = small_prg ? PRG_MASK_SMALL : PRG_MASK_FULL;
    assign mode = low_mode_e'(low_reg[7:6]);

    // one mixer per source: swap registers, then low register, then fixed top
    for (genvar g = 0; g < NUM_PRG_SWAP + 2; g++) begin : g_mix
        byte_t src;
        if (g < NUM_PRG_SWAP) begin : g_swap
            assign src = swap_regs[g];
        end else if (g == NUM_PRG_SWAP) begin : g_low
            assign src = low_reg;
        end else begin : g_top
            assign src = '1;
        end
        assign mixed[g] = (src & mask) | (outer_bank & ~mask);
    end

    always_comb begin
        bank   = '0;
        rom_cs = 1'b0;
        ram_cs = 1'b0;
        if (win == WIN_LOW) begin
            unique case (mode)
                LOW_ROM_A, LOW_ROM_B: begin
                    bank   = mixed[NUM_PRG_SWAP];
                    rom_cs = 1'b1;
                end
                LOW_RAM: ram_cs = 1'b1;
                LOW_OPEN: ;
            endcase
        end else if (win == WIN_TOP) begin
            bank   = mixed[NUM_PRG_SWAP+1];
            rom_cs = 1'b1;
        end else if (win >= WIN_IDX) begin
            bank   = mixed[win - WIN_IDX];
            rom_cs = 1'b1;
        end
        prg_addr = {bank, cpu_addr[OFS_W-1:0]};
    end
endmodule

// File: rtl/mapper_chr_map.sv
module mapper_chr_map
    import mapper_pkg::*;
#(
    parameter int PPU_AW = 13,
    localparam int SEL_W = $clog2(NUM_CHR_SLOTS),
    localparam int OFS_W = PPU_AW - SEL_W,
    localparam int OUT_W = DATA_W + OFS_W
) (
    input  logic [PPU_AW-1:0]         ppu_addr,
    input  byte_t [NUM_CHR_SLOTS-1:0] chr_regs,
    input  logic                      small_chr,
    output logic [OUT_W-1:0]          chr_addr
);
    logic [SEL_W-1:0] slot;
    byte_t            mask;
    byte_t            bank;

    assign slot = ppu_addr[PPU_AW-1:OFS_W];
    assign mask = small_chr ? CHR_MASK_SMALL : CHR_MASK_FULL;

    always_comb begin
        bank     = chr_regs[slot] & mask;
        chr_addr = {bank, ppu_addr[OFS_W-1:0]};
    end
endmodule

// File: rtl/bank_mapper_top.sv
module bank_mapper_top
    import mapper_pkg::*;
#(
    parameter int CPU_AW = 16,
    parameter int PPU_AW = 13,
    localparam int PRG_AW = DATA_W + CPU_AW - 3,
    localparam int CHR_AW = DATA_W + PPU_AW - $clog2(NUM_CHR_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    input  logic [PPU_AW-1:0] ppu_addr,
    input  logic              cfg_small_prg,
    input  logic              cfg_small_chr,
    input  logic [DATA_W-1:0] outer_bank,
    output logic [PRG_AW-1:0] prg_addr,
    output logic              prg_rom_cs,
    output logic              prg_ram_cs,
    output logic [CHR_AW-1:0] chr_addr,
    output logic [1:0]        mirror_code,
    output logic              irq_wr,
    output logic [IDX_W-1:0]  irq_reg_sel,
    output logic [DATA_W-1:0] irq_wr_data
);
    regs_t regs_q;
    byte_t mirror_reg;

    mapper_regfile u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_win     (cpu_addr[CPU_AW-1:CPU_AW-3]),
        .cpu_we      (cpu_we),
        .cpu_wdata   (cpu_wdata),
        .regs_q      (regs_q),
        .irq_wr      (irq_wr),
        .irq_reg_sel (irq_reg_sel),
        .irq_wr_data (irq_wr_data)
    );

    mapper_prg_map #(.CPU_AW(CPU_AW)) u_prg (
        .cpu_addr   (cpu_addr),
        .low_reg    (regs_q.bank[REG_LOW_CTRL]),
        .swap_regs  (regs_q.bank[REG_LOW_CTRL+NUM_PRG_SWAP:REG_LOW_CTRL+1]),
        .small_prg  (cfg_small_prg),
        .outer_bank (outer_bank),
        .prg_addr   (prg_addr),
        .rom_cs     (prg_rom_cs),
        .ram_cs     (prg_ram_cs)
    );

    mapper_chr_map #(.PPU_AW(PPU_AW)) u_chr (
        .ppu_addr  (ppu_addr),
        .chr_regs  (regs_q.bank[NUM_CHR_SLOTS-1:0]),
        .small_chr (cfg_small_chr),
        .chr_addr  (chr_addr)
    );

    assign mirror_reg  = regs_q.bank[REG_MIRROR];
    assign mirror_code = mirror_reg[1:0] ^ {1'b0, ~mirror_reg[1]};
endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
    parameter int CPU_AW = 16,
    parameter int PRG_AW = 21,
    parameter int CHR_AW = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic              cpu_we,
    input logic              cfg_small_prg,
    input logic              cfg_small_chr,
    input logic [PRG_AW-1:0] prg_addr,
    input logic              prg_rom_cs,
    input logic              prg_ram_cs,
    input logic [CHR_AW-1:0] chr_addr,
    input logic [1:0]        mirror_code,
    input logic              irq_wr
);
    localparam int OFS = CPU_AW - 3;
    logic [2:0] win;
    assign win = cpu_addr[CPU_AW-1:CPU_AW-3];

    p_cs_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prg_rom_cs, prg_ram_cs}));

    p_no_cs_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (win < 3'd3) |-> (!prg_rom_cs && !prg_ram_cs));

    p_offset_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win >= 3'd4) |-> (prg_rom_cs && prg_addr[OFS-1:0] == cpu_addr[OFS-1:0]));

    p_top_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win == 3'd7 && !cfg_small_prg) |-> (prg_addr[OFS+4:OFS] == 5'h1F));

    p_top_fixed_small_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win == 3'd7 && cfg_small_prg) |-> (prg_addr[OFS+3:OFS] == 4'hF));

    p_chr_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_small_chr |-> !chr_addr[CHR_AW-1]);

    p_mirror_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && win == 3'd5) |=> $stable(mirror_code));

    p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wr |-> (cpu_we && win == 3'd5));
endmodule

bind bank_mapper_top mapper_checker #(
    .CPU_AW (CPU_AW),
    .PRG_AW (PRG_AW),
    .CHR_AW (CHR_AW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_addr      (cpu_addr),
    .cpu_we        (cpu_we),
    .cfg_small_prg (cfg_small_prg),
    .cfg_small_chr (cfg_small_chr),
    .prg_addr      (prg_addr),
    .prg_rom_cs    (prg_rom_cs),
    .prg_ram_cs    (prg_ram_cs),
    .chr_addr      (chr_addr),
    .mirror_code   (mirror_code),
    .irq_wr        (irq_wr)
);

// File: tb/bank_mapper_top_tb_top.sv
module bank_mapper_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic [12:0] ppu_addr = '0;
    logic        cfg_small_prg = 1'b0;
    logic        cfg_small_chr = 1'b0;
    logic [7:0]  outer_bank = '0;
    logic [20:0] prg_addr;
    logic        prg_rom_cs, prg_ram_cs;
    logic [17:0] chr_addr;
    logic [1:0]  mirror_code;
    logic        irq_wr;
    logic [3:0]  irq_reg_sel;
    logic [7:0]  irq_wr_data;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    bank_mapper_top dut_i (.*);

    typedef struct packed {
        logic [15:0] a;
        logic [12:0] p;
        logic [20:0] prg;
        logic [17:0] chr;
        logic        rom;
        logic        ram;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{16'h8123, 13'h0000, 21'h006123, 18'h04800, 1'b1, 1'b0},
        '{16'hA456, 13'h0401, 21'h03C456, 18'h0D001, 1'b1, 1'b0},
        '{16'hC7FF, 13'h0BFF, 21'h00E7FF, 18'h15BFF, 1'b1, 1'b0},
        '{16'hE000, 13'h0C10, 21'h03E000, 18'h1E010, 1'b1, 1'b0},
        '{16'h6010, 13'h1000, 21'h00A010, 18'h26800, 1'b1, 1'b0},
        '{16'hFFFF, 13'h1400, 21'h03FFFF, 18'h2F000, 1'b1, 1'b0},
        '{16'h5000, 13'h1800, 21'h001000, 18'h37800, 1'b0, 1'b0},
        '{16'h0000, 13'h1FFF, 21'h000000, 18'h3C7FF, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0; cpu_addr = 16'h0000;
    endtask

    task automatic setreg(input logic [3:0] i, input logic [7:0] v);
        wr(16'h8000, {4'h0, i});
        wr(16'hA000, v);
    endtask

    task automatic look(input logic [15:0] a, input logic [12:0] p);
        @(negedge clk);
        cpu_addr = a; ppu_addr = p;
        #1;
    endtask

    task automatic irq_probe(input logic [3:0] i, input logic [7:0] v, input string tag);
        wr(16'h9FFF, {4'h0, i});
        @(negedge clk);
        cpu_addr = 16'hBFFF; cpu_wdata = v; cpu_we = 1'b1;
        #1;
        chk({tag, " irq_wr"}, 32'(irq_wr), 32'd1);
        chk({tag, " irq_reg_sel"}, 32'(irq_reg_sel), 32'(i));
        chk({tag, " irq_wr_data"}, 32'(irq_wr_data), 32'(v));
        @(negedge clk);
        cpu_we = 1'b0; cpu_addr = 16'h0000;
        #1;
        chk({tag, " irq_wr low after"}, 32'(irq_wr), 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        look(16'h8000, 13'h0400);
        chk("R12 mirror after reset", 32'(mirror_code), 32'd1);
        chk("R12 prg after reset", 32'(prg_addr), 32'h0);
        chk("R12 chr after reset", 32'(chr_addr), 32'h0);
        chk("R12 irq_wr idle", 32'(irq_wr), 32'd0);

        setreg(4'd0, 8'h12); setreg(4'd1, 8'h34); setreg(4'd2, 8'h56);
        setreg(4'd3, 8'h78); setreg(4'd4, 8'h9A); setreg(4'd5, 8'hBC);
        setreg(4'd6, 8'hDE); setreg(4'd7, 8'hF1); setreg(4'd8, 8'h05);
        setreg(4'd9, 8'h03); setreg(4'd10, 8'h1E); setreg(4'd11, 8'h27);

        // R3 R5 R6 R8 R9 table walk
        for (int k = 0; k < NV; k++) begin
            look(VEC[k].a, VEC[k].p);
            chk($sformatf("R5 prg_addr vec%0d", k), 32'(prg_addr), 32'(VEC[k].prg));
            chk($sformatf("R3 chr_addr vec%0d", k), 32'(chr_addr), 32'(VEC[k].chr));
            chk($sformatf("R9 rom_cs vec%0d", k), 32'(prg_rom_cs), 32'(VEC[k].rom));
            chk($sformatf("R9 ram_cs vec%0d", k), 32'(prg_ram_cs), 32'(VEC[k].ram));
        end

        // R4 reduced pattern mask
        cfg_small_chr = 1'b1;
        look(16'h0000, 13'h1FFF);
        chk("R4 small chr mask", 32'(chr_addr), 32'h1C7FF);
        cfg_small_chr = 1'b0;

        // R7 R6 mask and outer bank
        outer_bank = 8'hA5;
        look(16'hE000, 13'h0);
        chk("R6 top bank full mask outer", 32'(prg_addr), 32'h17E000);
        cfg_small_prg = 1'b1;
        look(16'hE000, 13'h0);
        chk("R7 top bank small mask outer", 32'(prg_addr), 32'h15E000);
        look(16'hA000, 13'h0);
        chk("R7 swap bank small mask outer", 32'(prg_addr), 32'h15C000);
        cfg_small_prg = 1'b0; outer_bank = 8'h00;

        // R8 low window modes
        setreg(4'd8, 8'h45);
        look(16'h6000, 13'h0);
        chk("R8 open rom_cs", 32'(prg_rom_cs), 32'd0);
        chk("R8 open ram_cs", 32'(prg_ram_cs), 32'd0);
        setreg(4'd8, 8'hC5);
        look(16'h6ABC, 13'h0);
        chk("R8 ram cs", 32'({prg_rom_cs, prg_ram_cs}), 32'b01);
        chk("R8 ram addr", 32'(prg_addr), 32'h00ABC);
        setreg(4'd8, 8'h85);
        look(16'h6000, 13'h0);
        chk("R8 rom alt mode", 32'({prg_rom_cs, prg_ram_cs}), 32'b10);
        chk("R8 rom alt addr", 32'(prg_addr), 32'h0A000);

        // R10 mirroring
        setreg(4'd12, 8'h00); #1; chk("R10 mirror 0", 32'(mirror_code), 32'd1);
        setreg(4'd12, 8'h01); #1; chk("R10 mirror 1", 32'(mirror_code), 32'd0);
        setreg(4'd12, 8'h02); #1; chk("R10 mirror 2", 32'(mirror_code), 32'd2);
        setreg(4'd12, 8'h03); #1; chk("R10 mirror 3", 32'(mirror_code), 32'd3);
        setreg(4'd12, 8'hFC); #1; chk("R10 mirror upper bits", 32'(mirror_code), 32'd1);

        // R1 only low nibble latched
        wr(16'h8000, 8'hF2);
        wr(16'hA000, 8'h99);
        look(16'h0000, 13'h0800);
        chk("R1 index low nibble", 32'(chr_addr), 32'h26400);

        // R2 other windows ignored, index kept
        wr(16'h8000, 8'h0C);
        wr(16'hC000, 8'h02);
        wr(16'h6000, 8'h07);
        #1;
        chk("R2 stray write no effect", 32'(mirror_code), 32'd1);
        wr(16'hA000, 8'h03);
        #1;
        chk("R2 index kept after stray", 32'(mirror_code), 32'd3);

        // R11 interrupt-side writes
        irq_probe(4'd13, 8'h81, "R11 idx13");
        irq_probe(4'd14, 8'h33, "R11 idx14");
        irq_probe(4'd15, 8'hC4, "R11 idx15");
        look(16'h8000, 13'h0000);
        chk("R11 chr0 untouched", 32'(chr_addr), 32'h04800);
        chk("R11 prg9 untouched", 32'(prg_addr), 32'h06000);
        look(16'hC000, 13'h0800);
        chk("R11 chr2 untouched", 32'(chr_addr), 32'h26400);
        chk("R11 prg11 untouched", 32'(prg_addr), 32'h0E000);
        chk("R11 mirror untouched", 32'(mirror_code), 32'd3);

        // R12 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        look(16'hA000, 13'h0400);
        chk("R12 mirror after rerun reset", 32'(mirror_code), 32'd1);
        chk("R12 chr after rerun reset", 32'(chr_addr), 32'h0);
        chk("R12 prg after rerun reset", 32'(prg_addr), 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule